// File: doc/BRIEF.md
# Serial Receive Loopback Router

This block sits in front of a synchronous serial receiver and picks where the receiver's clock, frame sync and data lanes come from. There are four sources. The first is the receive pins. The second borrows the transmit clock and/or transmit frame sync as the pads see them, which gives synchronous transmit-receive operation. The third is a pad loopback, in which all three receive signals come from the transmit pad inputs, so the output buffers are exercised. The fourth is a digital loopback, in which the core's own transmit outputs feed the receiver directly and every pad output enable is forced inactive.

All mode controls are sampled on the control clock. They reach the routing only in cycles where the receiver is held in reset, so a mode change can never cut a receive clock in half. A pin-mode control can hand the receive pins over to general-purpose use. In that mode, any receive signal that would otherwise come from a receive pin is held at a fixed idle level. A two-bit status output reports the active routing mode.

For digital loopback to carry traffic, the core's internal clock and frame-sync generators must be running, because they produce the transmit clock and frame sync.

Top module: `rx_loop_router`

## Requirements
- R1: After reset all captured controls are clear. The receive clock, frame sync and data then follow the receive pins, and each pad output enable follows its core request (active high by default).
- R2: Control inputs are captured on a rising clock edge only while `rx_hold` is high. Changes made while `rx_hold` is low have no effect on routing, output enables or status.
- R3: Synchronous select bit 0 routes the transmit-clock pad input to the receive clock. Select bit 1 routes the transmit frame-sync pad input to the receive frame sync. Each bit acts independently, and data still comes from the receive pins.
- R4: Pad loopback routes the transmit clock, frame sync and data pad inputs to the receive clock, frame sync and data. The output enables keep following the requests.
- R5: Digital loopback routes the core's transmit clock, frame sync and data outputs to the receive clock, frame sync and data.
- R6: During digital loopback, all five pad output enables are inactive: receive clock, transmit clock, receive frame sync, transmit frame sync and transmit data (bits 0 to 4 of `pad_oe`).
- R7: When several controls are set, digital loopback wins over pad loopback, pad loopback wins over the synchronous select bits, and those win over the receive pins.
- R8: In general-purpose pin mode, any receive signal that would come from a receive pin is held at its idle level (0 by default). Signals taken from the transmit side are unaffected.
- R9: `mode_stat` reads 0 for receive pins, 1 when any synchronous select bit is active, 2 for pad loopback and 3 for digital loopback, following the R7 priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | control clock |
| rst_n | input | 1 | asynchronous active-low reset |
| rx_hold | input | 1 | receiver held in reset; enables control capture |
| sync_sel | input | 2 | bit0 borrow transmit clock, bit1 borrow transmit frame sync |
| pad_lb_en | input | 1 | pad loopback request |
| dig_lb_en | input | 1 | digital loopback request |
| pin_gpio | input | 1 | receive pins in general-purpose mode |
| rx_clk_pin | input | 1 | receive clock pin |
| rx_fs_pin | input | 1 | receive frame-sync pin |
| rx_dat_pin | input | DAT_W | receive data pins |
| tx_clk_pad | input | 1 | transmit clock as seen at the pad input |
| tx_fs_pad | input | 1 | transmit frame sync as seen at the pad input |
| tx_dat_pad | input | DAT_W | transmit data as seen at the pad input |
| tx_clk_core | input | 1 | core transmit clock output |
| tx_fs_core | input | 1 | core transmit frame-sync output |
| tx_dat_core | input | DAT_W | core transmit data output |
| oe_req | input | 5 | core output-enable requests, active high |
| rx_clk | output | 1 | selected receive clock |
| rx_fs | output | 1 | selected receive frame sync |
| rx_dat | output | DAT_W | selected receive data |
| pad_oe | output | 5 | gated pad output enables |
| mode_stat | output | 2 | active routing mode code |

## Verification
Several mode requests can arrive in the same control word. The clearest case is digital loopback set together with pad loopback, the synchronous bits and general-purpose pin mode, all captured on one edge. The bench sweeps all 32 combinations of the five controls, captures each with `rx_hold` high, and then applies sixteen arithmetically spread pin patterns. For every pattern it predicts the clock, frame sync, data, output enables and status from the priority order, and compares them with the outputs. A second collision is a control change arriving while the receiver is released. This is provoked by rewriting the controls with `rx_hold` low across several edges, and it is judged by showing that the status and routing did not move.

// File: rtl/rx_loop_router_pkg.sv
package rx_loop_router_pkg;

   typedef enum logic [1:0] {
      RT_PINS = 2'd0,
      RT_SYNC = 2'd1,
      RT_PAD  = 2'd2,
      RT_DIG  = 2'd3
   } route_e;

   typedef struct packed {
      logic [1:0] sync_sel;
      logic       pad_lb;
      logic       dig_lb;
      logic       gpio;
   } mode_cfg_t;

   localparam int OE_LINES = 5;
   localparam int OE_RCLK  = 0;
   localparam int OE_XCLK  = 1;
   localparam int OE_RFS   = 2;
   localparam int OE_XFS   = 3;
   localparam int OE_DX    = 4;

   function automatic route_e resolve_route(input mode_cfg_t c);
      if (c.dig_lb)        return RT_DIG;
      else if (c.pad_lb)   return RT_PAD;
      else if (|c.sync_sel) return RT_SYNC;
      else                 return RT_PINS;
   endfunction

endpackage

// File: rtl/rx_loop_router_ctrl.sv
module rx_loop_router_ctrl
   import rx_loop_router_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      load,
   input  mode_cfg_t cfg_in,
   output mode_cfg_t cfg_q,
   output route_e    route
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_q <= '0;
      else if (load)
         cfg_q <= cfg_in;
   end

   always_comb route = resolve_route(cfg_q);

endmodule

// File: rtl/rx_loop_router_sel.sv
module rx_loop_router_sel
   import rx_loop_router_pkg::*;
#(
   parameter int   DAT_W    = 2,
   parameter logic IDLE_CLK = 1'b0,
   parameter logic IDLE_FS  = 1'b0,
   parameter logic IDLE_DAT = 1'b0
) (
   input  mode_cfg_t        cfg,
   input  logic             pin_clk,
   input  logic             pin_fs,
   input  logic [DAT_W-1:0] pin_dat,
   input  logic             pad_clk,
   input  logic             pad_fs,
   input  logic [DAT_W-1:0] pad_dat,
   input  logic             core_clk,
   input  logic             core_fs,
   input  logic [DAT_W-1:0] core_dat,
   output logic             sel_clk,
   output logic             sel_fs,
   output logic [DAT_W-1:0] sel_dat
);

   logic             gated_clk;
   logic             gated_fs;
   logic [DAT_W-1:0] gated_dat;

   always_comb begin
      gated_clk = cfg.gpio ? IDLE_CLK : pin_clk;
      gated_fs  = cfg.gpio ? IDLE_FS  : pin_fs;
   end

   always_comb begin
      if (cfg.dig_lb)                             sel_clk = core_clk;
      else if (cfg.pad_lb || cfg.sync_sel[0])     sel_clk = pad_clk;
      else                                        sel_clk = gated_clk;
   end

   always_comb begin
      if (cfg.dig_lb)                             sel_fs = core_fs;
      else if (cfg.pad_lb || cfg.sync_sel[1])     sel_fs = pad_fs;
      else                                        sel_fs = gated_fs;
   end

   for (genvar i = 0; i < DAT_W; i++) begin : g_lane
      always_comb begin
         gated_dat[i] = cfg.gpio ? IDLE_DAT : pin_dat[i];
         if (cfg.dig_lb)      sel_dat[i] = core_dat[i];
         else if (cfg.pad_lb) sel_dat[i] = pad_dat[i];
         else                 sel_dat[i] = gated_dat[i];
      end
   end

endmodule

// File: rtl/rx_loop_router_oe.sv
module rx_loop_router_oe
   import rx_loop_router_pkg::*;
#(
   parameter bit OE_ACT_LOW = 1'b0
) (
   input  route_e              route,
   input  logic [OE_LINES-1:0] req,
   output logic [OE_LINES-1:0] pad_oe
);

   logic [OE_LINES-1:0] allow;

   always_comb allow = (route == RT_DIG) ? '0 : req;

   if (OE_ACT_LOW) begin : g_low
      always_comb pad_oe = ~allow;
   end else begin : g_high
      always_comb pad_oe = allow;
   end

endmodule

// File: rtl/rx_loop_router.sv
module rx_loop_router
   import rx_loop_router_pkg::*;
#(
   parameter int   DAT_W      = 2,
   parameter bit   OE_ACT_LOW = 1'b0,
   parameter logic IDLE_CLK   = 1'b0,
   parameter logic IDLE_FS    = 1'b0,
   parameter logic IDLE_DAT   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_hold,
   input  logic [1:0]       sync_sel,
   input  logic             pad_lb_en,
   input  logic             dig_lb_en,
   input  logic             pin_gpio,
   input  logic             rx_clk_pin,
   input  logic             rx_fs_pin,
   input  logic [DAT_W-1:0] rx_dat_pin,
   input  logic             tx_clk_pad,
   input  logic             tx_fs_pad,
   input  logic [DAT_W-1:0] tx_dat_pad,
   input  logic             tx_clk_core,
   input  logic             tx_fs_core,
   input  logic [DAT_W-1:0] tx_dat_core,
   input  logic [4:0]       oe_req,
   output logic             rx_clk,
   output logic             rx_fs,
   output logic [DAT_W-1:0] rx_dat,
   output logic [4:0]       pad_oe,
   output logic [1:0]       mode_stat
);

   if (DAT_W < 1) begin : g_bad_width
      $error("rx_loop_router: DAT_W must be at least 1");
   end
   if (OE_LINES != 5) begin : g_bad_oe
      $error("rx_loop_router: output-enable count mismatch");
   end

   mode_cfg_t cfg_in;
   mode_cfg_t cfg_q;
   route_e    route;

   always_comb begin
      cfg_in.sync_sel = sync_sel;
      cfg_in.pad_lb   = pad_lb_en;
      cfg_in.dig_lb   = dig_lb_en;
      cfg_in.gpio     = pin_gpio;
   end

   rx_loop_router_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (rx_hold),
      .cfg_in (cfg_in),
      .cfg_q  (cfg_q),
      .route  (route)
   );

   rx_loop_router_sel #(
      .DAT_W    (DAT_W),
      .IDLE_CLK (IDLE_CLK),
      .IDLE_FS  (IDLE_FS),
      .IDLE_DAT (IDLE_DAT)
   ) u_sel (
      .cfg      (cfg_q),
      .pin_clk  (rx_clk_pin),
      .pin_fs   (rx_fs_pin),
      .pin_dat  (rx_dat_pin),
      .pad_clk  (tx_clk_pad),
      .pad_fs   (tx_fs_pad),
      .pad_dat  (tx_dat_pad),
      .core_clk (tx_clk_core),
      .core_fs  (tx_fs_core),
      .core_dat (tx_dat_core),
      .sel_clk  (rx_clk),
      .sel_fs   (rx_fs),
      .sel_dat  (rx_dat)
   );

   rx_loop_router_oe #(
      .OE_ACT_LOW (OE_ACT_LOW)
   ) u_oe (
      .route  (route),
      .req    (oe_req),
      .pad_oe (pad_oe)
   );

   always_comb mode_stat = route;

endmodule

// File: rtl/rx_loop_router_chk.sv
module rx_loop_router_chk #(
   parameter int DAT_W      = 2,
   parameter bit OE_ACT_LOW = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_hold,
   input logic             rx_clk,
   input logic             rx_fs,
   input logic [DAT_W-1:0] rx_dat,
   input logic             tx_clk_pad,
   input logic             tx_fs_pad,
   input logic [DAT_W-1:0] tx_dat_pad,
   input logic             tx_clk_core,
   input logic             tx_fs_core,
   input logic [DAT_W-1:0] tx_dat_core,
   input logic [4:0]       oe_req,
   input logic [4:0]       pad_oe,
   input logic [1:0]       mode_stat
);

   logic [4:0] oe_off;
   logic [4:0] oe_fwd;
   always_comb begin
      oe_off = OE_ACT_LOW ? 5'h1F : 5'h00;
      oe_fwd = OE_ACT_LOW ? ~oe_req : oe_req;
   end

   // R2: status frozen while the receiver is released
   p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(rx_hold) && $past(rst_n)) |-> $stable(mode_stat))
      else $error("p_frozen_r2");

   // R4: pad loopback takes all receive signals from the pad inputs
   p_pad_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_stat == 2'd2) |-> (rx_clk == tx_clk_pad && rx_fs == tx_fs_pad && rx_dat == tx_dat_pad))
      else $error("p_pad_path_r4");

   // R5: digital loopback takes all receive signals from the core
   p_dig_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_stat == 2'd3) |-> (rx_clk == tx_clk_core && rx_fs == tx_fs_core && rx_dat == tx_dat_core))
      else $error("p_dig_path_r5");

   // R6: no pad driven during digital loopback
   p_oe_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_stat == 2'd3) |-> (pad_oe == oe_off))
      else $error("p_oe_off_r6");

   // R1: enables follow requests outside digital loopback
   p_oe_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_stat != 2'd3) |-> (pad_oe == oe_fwd))
      else $error("p_oe_pass_r1");

   // R3: synchronous mode borrows the transmit clock or frame sync pad input
   p_sync_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_stat == 2'd1) |-> (rx_clk == tx_clk_pad || rx_fs == tx_fs_pad))
      else $error("p_sync_src_r3");

endmodule

bind rx_loop_router rx_loop_router_chk #(
   .DAT_W      (DAT_W),
   .OE_ACT_LOW (OE_ACT_LOW)
) u_chk (.*);

// File: tb/rx_loop_router_bench.sv
`timescale 1ns/1ps
module rx_loop_router_bench;
   localparam int DW = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          rx_hold;
   logic [1:0]    sync_sel;
   logic          pad_lb_en, dig_lb_en, pin_gpio;
   logic          rx_clk_pin, rx_fs_pin, tx_clk_pad, tx_fs_pad, tx_clk_core, tx_fs_core;
   logic [DW-1:0] rx_dat_pin, tx_dat_pad, tx_dat_core;
   logic [4:0]    oe_req;
   logic          rx_clk, rx_fs;
   logic [DW-1:0] rx_dat;
   logic [4:0]    pad_oe;
   logic [1:0]    mode_stat;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   rx_loop_router #(.DAT_W(DW)) u_rx_loop_router (.*);

   task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic drive_pat(input int p);
      logic [31:0] w;
      w = p * 32'h9E3779B1;
      rx_clk_pin  = w[3];    rx_fs_pin  = w[7];  rx_dat_pin  = w[12:11];
      tx_clk_pad  = w[14];   tx_fs_pad  = w[17]; tx_dat_pad  = w[20:19];
      tx_clk_core = w[22];   tx_fs_core = w[25]; tx_dat_core = w[28:27];
      oe_req      = {w[30:29], w[1:0], w[5]};
   endtask

   task automatic apply_cfg(input logic [1:0] s, input logic p, input logic d, input logic g);
      @(negedge clk);
      sync_sel = s; pad_lb_en = p; dig_lb_en = d; pin_gpio = g; rx_hold = 1'b1;
      @(negedge clk);
      rx_hold = 1'b0;
   endtask

   // expected outputs for captured controls s,p,d,g
   task automatic check_all(input logic [1:0] s, input logic p, input logic d, input logic g);
      logic          e_clk, e_fs;
      logic [DW-1:0] e_dat;
      logic [1:0]    e_st;
      string         tag;
      int            nact;
      nact = int'(d) + int'(p) + int'(|s);
      if (nact > 1)   tag = "R7";
      else if (d)     tag = "R5";
      else if (p)     tag = "R4";
      else if (|s)    tag = "R3";
      else if (g)     tag = "R8";
      else            tag = "R1";
      e_clk = d ? tx_clk_core : (p || s[0]) ? tx_clk_pad : (g ? 1'b0 : rx_clk_pin);
      e_fs  = d ? tx_fs_core  : (p || s[1]) ? tx_fs_pad  : (g ? 1'b0 : rx_fs_pin);
      e_dat = d ? tx_dat_core : p ? tx_dat_pad : (g ? '0 : rx_dat_pin);
      e_st  = d ? 2'd3 : p ? 2'd2 : (|s) ? 2'd1 : 2'd0;
      chk(tag, "rx_clk", {7'd0, rx_clk}, {7'd0, e_clk});
      chk(tag, "rx_fs",  {7'd0, rx_fs},  {7'd0, e_fs});
      chk(tag, "rx_dat", {6'd0, rx_dat}, {6'd0, e_dat});
      chk(d ? "R6" : "R1", "pad_oe", {3'd0, pad_oe}, {3'd0, (d ? 5'd0 : oe_req)});
      chk("R9", "mode_stat", {6'd0, mode_stat}, {6'd0, e_st});
   endtask

   initial begin : wd
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; rx_hold = 1'b0; sync_sel = 2'b00;
      pad_lb_en = 1'b0; dig_lb_en = 1'b0; pin_gpio = 1'b0;
      drive_pat(3);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_all(2'b00, 1'b0, 1'b0, 1'b0);            // R1 reset state
      rst_n = 1'b1;
      @(negedge clk);
      check_all(2'b00, 1'b0, 1'b0, 1'b0);            // R1 after release

      // sweep of every control combination (R3..R9)
      for (int c = 0; c < 32; c++) begin
         apply_cfg(c[1:0], c[2], c[3], c[4]);
         for (int p = 1; p <= 16; p++) begin
            drive_pat(p);
            #1;
            check_all(c[1:0], c[2], c[3], c[4]);
            @(negedge clk);
         end
      end

      // R2: controls rewritten with receiver released must not take effect
      apply_cfg(2'b00, 1'b0, 1'b1, 1'b0);
      sync_sel = 2'b11; pad_lb_en = 1'b1; dig_lb_en = 1'b0; pin_gpio = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         drive_pat(k + 20);
         #1;
         chk("R2", "mode_stat held", {6'd0, mode_stat}, 8'd3);
         chk("R2", "rx_clk held", {7'd0, rx_clk}, {7'd0, tx_clk_core});
         chk("R2", "pad_oe held", {3'd0, pad_oe}, 8'd0);
      end
      apply_cfg(2'b00, 1'b0, 1'b0, 1'b0);
      #1;
      chk("R2", "mode_stat after capture", {6'd0, mode_stat}, 8'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule